// File: doc/BRIEF.md
# Page Register Column Pointer

This block is the column-addressing logic that sits beside the page register of a small-page NAND memory. A page holds 528 bytes in three areas: a lower main half (bytes 0 to 255), an upper main half (256 to 511) and a 16-byte spare area (512 to 527). Instead of sending the two top column bits, the host first issues a pointer command. The pointer command picks the area, and the first address byte then gives the offset inside that area. Command, address and data bytes all arrive on one shared byte bus. Each byte is qualified by a one-cycle strobe that is already synchronised to the block clock.

During a serial read, each read strobe returns the byte at the current column and moves the column on by one. Once the last column has gone out, the row advances and the column restarts, so the next page can be streamed. The block asks for the next page with a pulse, but it never crosses a 32-page block boundary: at the last page of a block the stream stops. During a data load, each write strobe stores a byte into the page register and steps the column. The page register itself is a plain register file.

Top module: `pgreg_colptr`

## Requirements
- R1: After reset, `area` is 0 (lower half), `column` and `row` are 0, and `end_of_page` and `next_page_req` are low. The block is in read mode, but no read stream is active.
- R2: Command 00h selects area code 0, and the column becomes the address byte. Command 01h selects area code 1, and the column becomes 256 plus the address byte. The column byte is the first address cycle after a read or load command.
- R3: Command 50h selects area code 2, and the column becomes 512 plus address bits 3:0. Address bits 7:4 have no effect.
- R4: An area selected by 00h or 50h stays selected through program confirm (10h), erase confirm (D0h) and reset (FFh).
- R5: Area code 1 is one-shot. It returns to code 0 at each of these points: the last address cycle of a read, program confirm 10h, erase confirm D0h, and reset FFh.
- R6: While a read stream is active, each read strobe registers the byte stored at the current column on `dout` and increments `column`.
- R7: A read strobe at column 527 raises `end_of_page` for one cycle. If the block end has not been reached, that strobe also increments `row`, pulses `next_page_req`, and restarts the column at 512 when the area code is 2, or at 0 otherwise.
- R8: `block_end` is high when the low 5 bits of `row` are all ones. A read strobe at column 527 in that state ends the stream with no `next_page_req` and no row change. Any later read strobe leaves `column`, `row` and `dout` unchanged and raises no `end_of_page`.
- R9: After command 80h and its address cycles, each write strobe stores the bus byte at the current column and increments the column. At column 527 the column holds instead of wrapping, so any further bytes land on column 527.
- R10: After command 60h, all three address cycles load `row` (row byte 0 first), and `column` is not changed.
- R11: A write strobe outside a load, and a read strobe while no read stream is active (for example after command 70h), change neither the page contents nor `column` nor `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command strobe; `bus_in` holds a command byte |
| addr_we | input | 1 | Address strobe; `bus_in` holds an address byte |
| din_we | input | 1 | Data-load strobe; `bus_in` holds a data byte |
| rd_pulse | input | 1 | Read strobe, one per falling read-enable edge |
| bus_in | input | 8 | Shared command/address/data byte |
| dout | output | 8 | Byte read out by the last accepted read strobe |
| column | output | 10 | Current column pointer, 0 to 527 |
| row | output | 17 | Current page address |
| area | output | 2 | Pointer area: 0 lower half, 1 upper half, 2 spare |
| end_of_page | output | 1 | One-cycle pulse after column 527 is read |
| next_page_req | output | 1 | One-cycle request to load the following page |
| block_end | output | 1 | Current row is the last page of its 32-page block |

## Verification
The hardest state to reach from the ports is the stop at a block boundary. It needs the row at the last page of a block and the column at 527 at the same time. Streaming to that point would take thousands of read strobes. The bench gets there directly: it selects the spare pointer with offset 15, which puts the column at 527, and loads row byte 0x1F in the same address sequence. A single read strobe then tests the stop. A second strobe checks that the finished stream ignores further reads. Page crossing in the lower-half mode is reached the same way: a one-shot upper-half pointer at byte 255 leaves only seventeen strobes to the page edge.

// File: rtl/pgcol_pkg.sv
package pgcol_pkg;

  typedef enum logic [1:0] {
    AREA_A = 2'd0,
    AREA_B = 2'd1,
    AREA_C = 2'd2
  } area_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_ERASE = 2'd3
  } op_e;

  localparam logic [7:0] CMD_PTR_A     = 8'h00;
  localparam logic [7:0] CMD_PTR_B     = 8'h01;
  localparam logic [7:0] CMD_PTR_C     = 8'h50;
  localparam logic [7:0] CMD_LOAD      = 8'h80;
  localparam logic [7:0] CMD_PROG_GO   = 8'h10;
  localparam logic [7:0] CMD_ERS_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERS_GO    = 8'hD0;
  localparam logic [7:0] CMD_RESET     = 8'hFF;

endpackage

// File: rtl/pgcol_ptr_ctrl.sv
module pgcol_ptr_ctrl
  import pgcol_pkg::*;
#(
  parameter int ROW_CYC = 3,
  localparam int IDX_W  = $clog2(ROW_CYC + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic             addr_we,
  input  logic [7:0]       bus_in,
  output area_e            area_o,
  output op_e              op_o,
  output logic             col_we,
  output logic             row_we,
  output logic [IDX_W-1:0] row_idx,
  output logic             launch
);

  localparam logic [IDX_W-1:0] IDX_DONE = IDX_W'(ROW_CYC + 1);

  area_e            area_q, area_d;
  op_e              op_q, op_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] last_idx;
  logic             addr_live;

  assign last_idx  = (op_q == OP_ERASE) ? IDX_W'(ROW_CYC - 1) : IDX_W'(ROW_CYC);
  assign addr_live = addr_we && (op_q != OP_NONE) && (idx_q <= last_idx);
  assign col_we    = addr_live && (op_q != OP_ERASE) && (idx_q == '0);
  assign row_we    = addr_live && !col_we;
  assign row_idx   = (op_q == OP_ERASE) ? idx_q : idx_q - IDX_W'(1);
  assign launch    = addr_live && (op_q == OP_READ) && (idx_q == IDX_W'(ROW_CYC));

  always_comb begin
    area_d = area_q;
    op_d   = op_q;
    idx_d  = idx_q;
    if (cmd_we) begin
      case (bus_in)
        CMD_PTR_A:     begin area_d = AREA_A; op_d = OP_READ; idx_d = '0; end
        CMD_PTR_B:     begin area_d = AREA_B; op_d = OP_READ; idx_d = '0; end
        CMD_PTR_C:     begin area_d = AREA_C; op_d = OP_READ; idx_d = '0; end
        CMD_LOAD:      begin op_d = OP_LOAD;  idx_d = '0; end
        CMD_ERS_SETUP: begin op_d = OP_ERASE; idx_d = '0; end
        CMD_PROG_GO, CMD_ERS_GO: begin
          op_d = OP_NONE;
          if (area_q == AREA_B) area_d = AREA_A;
        end
        CMD_RESET: begin
          op_d  = OP_READ;
          idx_d = IDX_DONE;
          if (area_q == AREA_B) area_d = AREA_A;
        end
        default: op_d = OP_NONE;
      endcase
    end else if (addr_live) begin
      idx_d = idx_q + IDX_W'(1);
      if (launch && area_q == AREA_B) area_d = AREA_A;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      area_q <= AREA_A;
      op_q   <= OP_READ;
      idx_q  <= IDX_DONE;
    end else begin
      area_q <= area_d;
      op_q   <= op_d;
      idx_q  <= idx_d;
    end
  end

  assign area_o = area_q;
  assign op_o   = op_q;

  // R5
  oneshot_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch && area_q == AREA_B |=> area_q == AREA_A);

  // R4
  sticky_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && area_q == AREA_C && bus_in != CMD_PTR_A && bus_in != CMD_PTR_B
    |=> area_q == AREA_C);

endmodule

// File: rtl/pgcol_col_ctr.sv
module pgcol_col_ctr
  import pgcol_pkg::*;
#(
  parameter int HALF_BYTES  = 256,
  parameter int SPARE_BYTES = 16,
  parameter int ROW_W       = 17,
  parameter int BLK_PAGES   = 32,
  parameter int IDX_W       = 3,
  localparam int PAGE_BYTES = 2 * HALF_BYTES + SPARE_BYTES,
  localparam int COL_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  area_e            area,
  input  op_e              op,
  input  logic             cmd_we,
  input  logic             col_we,
  input  logic             row_we,
  input  logic [IDX_W-1:0] row_idx,
  input  logic             launch,
  input  logic [7:0]       bus_in,
  input  logic             rd_pulse,
  input  logic             din_we,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rd_en,
  output logic             wr_en,
  output logic             eop_o,
  output logic             nxt_o,
  output logic             blk_end_o
);

  localparam int SPARE_W = $clog2(SPARE_BYTES);
  localparam int BLK_W   = $clog2(BLK_PAGES);
  localparam logic [COL_W-1:0] LAST_COL   = COL_W'(PAGE_BYTES - 1);
  localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(2 * HALF_BYTES);

  logic [COL_W-1:0] col_q, col_d, col_base, col_restart;
  logic [ROW_W-1:0] row_q, row_d;
  logic             act_q, act_d;
  logic             eop_q, eop_d, nxt_q, nxt_d;
  logic             blk_end;

  assign blk_end = &row_q[BLK_W-1:0];
  assign rd_en   = rd_pulse && act_q;
  assign wr_en   = din_we && (op == OP_LOAD);

  always_comb begin
    case (area)
      AREA_B:  col_base = COL_W'(HALF_BYTES) + COL_W'(bus_in);
      AREA_C:  col_base = SPARE_BASE + COL_W'(bus_in[SPARE_W-1:0]);
      default: col_base = COL_W'(bus_in);
    endcase
    col_restart = (area == AREA_C) ? SPARE_BASE : '0;
  end

  always_comb begin
    col_d = col_q;
    row_d = row_q;
    act_d = act_q;
    eop_d = 1'b0;
    nxt_d = 1'b0;
    if (cmd_we) act_d = 1'b0;
    if (col_we) col_d = col_base;
    if (row_we) begin
      for (int b = 0; b < ROW_W; b++) begin
        if (b / 8 == int'(row_idx)) row_d[b] = bus_in[b % 8];
      end
    end
    if (launch) act_d = 1'b1;
    if (rd_en) begin
      if (col_q == LAST_COL) begin
        eop_d = 1'b1;
        if (blk_end) begin
          act_d = 1'b0;
        end else begin
          row_d = row_q + ROW_W'(1);
          col_d = col_restart;
          nxt_d = 1'b1;
        end
      end else begin
        col_d = col_q + COL_W'(1);
      end
    end
    if (wr_en) col_d = (col_q == LAST_COL) ? LAST_COL : col_q + COL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
      act_q <= 1'b0;
      eop_q <= 1'b0;
      nxt_q <= 1'b0;
    end else begin
      col_q <= col_d;
      row_q <= row_d;
      act_q <= act_d;
      eop_q <= eop_d;
      nxt_q <= nxt_d;
    end
  end

  assign col_o     = col_q;
  assign row_o     = row_q;
  assign eop_o     = eop_q;
  assign nxt_o     = nxt_q;
  assign blk_end_o = blk_end;

  // R9
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= LAST_COL);

  // R9
  load_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && col_q == LAST_COL |=> col_q == LAST_COL);

  // R6
  read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && col_q != LAST_COL |=> col_q == $past(col_q) + COL_W'(1));

  // R7
  page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && col_q == LAST_COL && !blk_end
    |=> nxt_q && eop_q && row_q == $past(row_q) + ROW_W'(1));

  // R8
  block_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && col_q == LAST_COL && blk_end |=> !act_q && !nxt_q && $stable(row_q));

  // R3
  spare_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_we && area == AREA_C |=> col_q >= SPARE_BASE);

endmodule

// File: rtl/pgcol_page_rf.sv
module pgcol_page_rf #(
  parameter int DEPTH = 528,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= mem[addr];
  end

  // R11
  no_dual_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));

endmodule

// File: rtl/pgreg_colptr.sv
module pgreg_colptr
  import pgcol_pkg::*;
#(
  parameter int HALF_BYTES  = 256,
  parameter int SPARE_BYTES = 16,
  parameter int ROW_W       = 17,
  parameter int BLK_PAGES   = 32,
  localparam int PAGE_BYTES = 2 * HALF_BYTES + SPARE_BYTES,
  localparam int COL_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic             addr_we,
  input  logic             din_we,
  input  logic             rd_pulse,
  input  logic [7:0]       bus_in,
  output logic [7:0]       dout,
  output logic [COL_W-1:0] column,
  output logic [ROW_W-1:0] row,
  output logic [1:0]       area,
  output logic             end_of_page,
  output logic             next_page_req,
  output logic             block_end
);

  localparam int ROW_CYC = (ROW_W + 7) / 8;
  localparam int IDX_W   = $clog2(ROW_CYC + 2);

  area_e            area_w;
  op_e              op_w;
  logic             col_we, row_we, launch, rd_en, wr_en;
  logic [IDX_W-1:0] row_idx;

  pgcol_ptr_ctrl #(.ROW_CYC(ROW_CYC)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_we  (cmd_we),
    .addr_we (addr_we),
    .bus_in  (bus_in),
    .area_o  (area_w),
    .op_o    (op_w),
    .col_we  (col_we),
    .row_we  (row_we),
    .row_idx (row_idx),
    .launch  (launch)
  );

  pgcol_col_ctr #(
    .HALF_BYTES  (HALF_BYTES),
    .SPARE_BYTES (SPARE_BYTES),
    .ROW_W       (ROW_W),
    .BLK_PAGES   (BLK_PAGES),
    .IDX_W       (IDX_W)
  ) u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .area      (area_w),
    .op        (op_w),
    .cmd_we    (cmd_we),
    .col_we    (col_we),
    .row_we    (row_we),
    .row_idx   (row_idx),
    .launch    (launch),
    .bus_in    (bus_in),
    .rd_pulse  (rd_pulse),
    .din_we    (din_we),
    .col_o     (column),
    .row_o     (row),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .eop_o     (end_of_page),
    .nxt_o     (next_page_req),
    .blk_end_o (block_end)
  );

  pgcol_page_rf #(.DEPTH(PAGE_BYTES)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (column),
    .wdata (bus_in),
    .rdata (dout)
  );

  assign area = area_w;

endmodule

// File: tb/pgreg_colptr_tb_top.sv
module pgreg_colptr_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0, addr_we = 1'b0, din_we = 1'b0, rd_pulse = 1'b0;
  logic [7:0]  bus_in = '0;
  logic [7:0]  dout;
  logic [9:0]  column;
  logic [16:0] row;
  logic [1:0]  area;
  logic        end_of_page, next_page_req, block_end;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pgreg_colptr dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .addr_we(addr_we),
    .din_we(din_we), .rd_pulse(rd_pulse), .bus_in(bus_in), .dout(dout),
    .column(column), .row(row), .area(area), .end_of_page(end_of_page),
    .next_page_req(next_page_req), .block_end(block_end)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk); cmd_we = 1'b1; bus_in = b;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic send_addr(input logic [7:0] b);
    @(negedge clk); addr_we = 1'b1; bus_in = b;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic send_addr4(input logic [7:0] c, input logic [16:0] r);
    send_addr(c);
    send_addr(r[7:0]);
    send_addr(r[15:8]);
    send_addr({7'd0, r[16]});
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); din_we = 1'b1; bus_in = b;
    @(negedge clk); din_we = 1'b0;
  endtask

  task automatic rd_byte();
    @(negedge clk); rd_pulse = 1'b1;
    @(negedge clk); rd_pulse = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 area", area, 0);
    check("R1 column", column, 0);
    check("R1 row", row, 0);
    check("R1 eop", end_of_page, 0);
    check("R1 nxt", next_page_req, 0);
  endtask

  task automatic t_base_a_b();
    send_cmd(8'h00); send_addr4(8'h33, 17'd1);
    check("R2 col A", column, 10'h033);
    check("R2 area A", area, 0);
    send_cmd(8'h01); send_addr(8'h33);
    check("R2 col B", column, 10'h133);
    check("R2 area B", area, 1);
    send_addr(8'h02); send_addr(8'h00); send_addr(8'h00);
    check("R5 fallback after read", area, 0);
  endtask

  task automatic t_spare();
    send_cmd(8'h50); send_addr4(8'hF7, 17'd2);
    check("R3 col C", column, 10'd519);
    check("R3 area C", area, 2);
  endtask

  task automatic t_load_read();
    send_cmd(8'h00); send_cmd(8'h80); send_addr4(8'h10, 17'd0);
    wr_byte(8'hA1); wr_byte(8'hB2); wr_byte(8'hC3);
    check("R9 col step", column, 10'h013);
    send_cmd(8'h10);
    send_cmd(8'h00); send_addr4(8'h10, 17'd0);
    wr_byte(8'h5A);
    check("R11 write outside load col", column, 10'h010);
    rd_byte();
    check("R6 dout 0", dout, 8'hA1);
    check("R6 col 0", column, 10'h011);
    rd_byte();
    check("R6 dout 1", dout, 8'hB2);
    rd_byte();
    check("R6 dout 2", dout, 8'hC3);
    check("R6 col 2", column, 10'h013);
  endtask

  task automatic t_saturate();
    send_cmd(8'h50); send_cmd(8'h80); send_addr4(8'h0E, 17'd0);
    check("R9 start col", column, 10'd526);
    wr_byte(8'h11);
    check("R9 col 527", column, 10'd527);
    wr_byte(8'h22); wr_byte(8'h33);
    check("R9 saturate", column, 10'd527);
    send_cmd(8'h10);
    check("R4 sticky C after program", area, 2);
    send_cmd(8'hFF);
    check("R4 sticky C after reset", area, 2);
    send_cmd(8'h50); send_addr4(8'h0E, 17'd0);
    rd_byte();
    check("R9 byte 526", dout, 8'h11);
    rd_byte();
    check("R9 last write wins", dout, 8'h33);
    check("R7 eop C", end_of_page, 1);
    check("R7 nxt C", next_page_req, 1);
    check("R7 row C", row, 1);
    check("R7 restart C", column, 10'd512);
  endtask

  task automatic t_block_end();
    send_cmd(8'h50); send_addr4(8'h0F, 17'h1F);
    check("R8 flag", block_end, 1);
    check("R8 start col", column, 10'd527);
    rd_byte();
    check("R8 eop", end_of_page, 1);
    check("R8 no request", next_page_req, 0);
    check("R8 row held", row, 17'h1F);
    rd_byte();
    check("R8 col after stop", column, 10'd527);
    check("R8 no eop after stop", end_of_page, 0);
    check("R8 dout after stop", dout, 8'h33);
  endtask

  task automatic t_row_cross();
    send_cmd(8'h01); send_addr4(8'hFF, 17'd5);
    check("R5 area after B read", area, 0);
    check("R2 col 511", column, 10'd511);
    for (int i = 0; i < 16; i++) rd_byte();
    check("R6 col reaches 527", column, 10'd527);
    check("R7 no early eop", end_of_page, 0);
    check("R8 not block end", block_end, 0);
    rd_byte();
    check("R7 eop A", end_of_page, 1);
    check("R7 nxt A", next_page_req, 1);
    check("R7 row A", row, 6);
    check("R7 restart A", column, 0);
    @(negedge clk);
    check("R7 eop one cycle", end_of_page, 0);
  endtask

  task automatic t_oneshot();
    send_cmd(8'h01); send_cmd(8'h80); send_addr4(8'h05, 17'd0);
    check("R2 col B load", column, 10'd261);
    check("R5 B held in load", area, 1);
    send_cmd(8'h10);
    check("R5 fallback program", area, 0);
    send_cmd(8'h01); send_cmd(8'hFF);
    check("R5 fallback reset", area, 0);
    send_cmd(8'h01); send_cmd(8'h60);
    send_addr(8'h40); send_addr(8'h02); send_addr(8'h00);
    check("R10 erase row", row, 17'h240);
    check("R10 erase col", column, 10'd261);
    check("R5 B held in erase", area, 1);
    send_cmd(8'hD0);
    check("R5 fallback erase", area, 0);
  endtask

  task automatic t_ignore();
    logic [7:0] d0;
    send_cmd(8'h00); send_addr4(8'h10, 17'd0);
    send_cmd(8'h70);
    d0 = dout;
    rd_byte();
    check("R11 rd inactive col", column, 10'h010);
    check("R11 rd inactive dout", dout, d0);
    wr_byte(8'h99);
    send_cmd(8'h00); send_addr4(8'h10, 17'd0);
    rd_byte();
    check("R11 page kept", dout, 8'hA1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base_a_b();
    t_spare();
    t_load_read();
    t_saturate();
    t_block_end();
    t_row_cross();
    t_oneshot();
    t_ignore();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule